// File: doc/BRIEF.md
# Disk Task File Register Bank

This block is the device-side register file of a parallel disk interface. The host reaches it with two active-low chip selects, a three-bit offset and active-low read and write strobes. The command-block select opens eight byte-wide locations: the 16-bit data port, error/precompensation, sector count, sector number, the two cylinder bytes, drive/head, and status/command. The control-block select opens the alternate status/device control location and the drive-address location. All other offsets float the bus.

The host strobes are brought into the core clock through synchronizer chains. Writes commit on the detected rising edge of the write strobe. Read data is a combinational function of the selects, the offset and the register contents, and it is driven only while the read strobe is low. An internal controller supplies the status byte and the write-gate level, and it can load the addressing fields and the error code in one cycle. Writes to the command register and the data port leave the block as single-cycle strobes. A data-port read also produces a strobe, which a separate sector buffer consumes.

While the status busy bit is set, the host is locked out. Every command-block read returns the status byte, and every command-block write is dropped. The device control register stays writable, so a soft reset can always be issued.

Top module: `tfr_bank`

## Requirements
- R1: With only the command select low, offsets 0..7 read as data port, error, sector count, sector number, cylinder low, cylinder high, drive/head and status. Offset 7 of the command block is the command register on write.
- R2: Reads float the bus (all output enables 0) when the read strobe is high, when neither select is low, when both selects are low, or when the control select is low at offsets 0..5. Writes under these conditions change no register.
- R3: After reset, error reads 01h, sector count 01h, sector number 01h, both cylinder bytes 00h, and the stored drive/head fields are zero.
- R4: While status bit 7 (busy) is 1, any command-block read, including the data port, returns the status byte on bits 7..0 only, with the 16-bit indication high.
- R5: A command-block write is dropped when busy is 1 in the cycle where the synchronized rising edge of the write strobe is detected. A device control write is accepted regardless of busy.
- R6: Drive/head reads as {1,0,1,drv,head[3:0]}. A write stores bit 4 as drv and bits 3..0 as head.
- R7: A control-block read at offset 6 returns the status byte. A read at offset 7 leaves bit 7 undriven and returns bit 6 as the write-gate input, bits 5..2 as the inverted head, bit 1 low when drv is 1, and bit 0 low when drv is 0.
- R8: One write produces one single-cycle effect, after the synchronized rising edge of the write strobe. A command write emits one cmd_stb pulse carrying the written byte.
- R9: A write to offset 1 of the command block (precompensation) leaves the error register unchanged.
- R10: When the data port is addressed and the device is not busy, host_cs16_n is low. A read drives all 16 bits from dp_rdata and emits one dp_rd_stb. A write emits one dp_wr_stb carrying the 16-bit word. No other access drives bits 15..8.
- R11: Device control bit 2 drives srst and bit 1 drives nien. While srst is 1, all command-block registers hold their reset values.
- R12: A ctl_load pulse loads sector count, sector number, both cylinder bytes, head and error from the controller inputs.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Core clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| host_cs_cmd_n | input | 1 | Command-block select, active low |
| host_cs_ctl_n | input | 1 | Control-block select, active low |
| host_addr | input | 3 | Register offset |
| host_rd_n | input | 1 | Read strobe, active low |
| host_wr_n | input | 1 | Write strobe, active low |
| host_din | input | 16 | Data from host |
| host_dout | output | 16 | Data to host |
| host_oe | output | 16 | Per-bit output enable for host_dout |
| host_cs16_n | output | 1 | Active-low 16-bit transfer indication |
| ctl_status | input | 8 | Status byte from controller, bit 7 busy |
| ctl_wgate_n | input | 1 | Active-low write-gate level |
| ctl_load | input | 1 | Load addressing fields and error code |
| ctl_scnt | input | 8 | Sector count to load |
| ctl_snum | input | 8 | Sector number to load |
| ctl_cyl | input | 16 | Cylinder to load |
| ctl_head | input | 4 | Head to load |
| ctl_err | input | 8 | Error code to load |
| dp_rdata | input | 16 | Word from sector buffer |
| dp_rd_stb | output | 1 | Data-port read pulse |
| dp_wr_stb | output | 1 | Data-port write pulse |
| dp_wdata | output | 16 | Word written by host |
| cmd_stb | output | 1 | Command write pulse |
| cmd_code | output | 8 | Command byte |
| scnt | output | 8 | Sector count |
| snum | output | 8 | Sector number |
| cyl | output | 16 | Cylinder |
| drv | output | 1 | Drive select bit |
| head | output | 4 | Head number |
| srst | output | 1 | Soft reset bit |
| nien | output | 1 | Interrupt disable bit |

## Verification
The hardest case to reach from the ports is a write that the host finishes while the device is idle, but that loses the busy race. The strobe passes through two synchronizer stages and an edge detector, and busy can rise inside that window. The bench releases the write strobe and raises busy in the same half-cycle. It then clears busy and reads the target register back to confirm that the old value survived. A scoreboard queue holds the expected command and data-port strobes, so a strobe that appears while busy is reported as unexpected.

// File: rtl/tfr_pkg.sv
package tfr_pkg;
   typedef enum logic [3:0] {
      ACC_NONE, ACC_DATA, ACC_ERRPC, ACC_SCNT, ACC_SNUM, ACC_CYLLO,
      ACC_CYLHI, ACC_DRVHD, ACC_STATCMD, ACC_ALTDEV, ACC_DADDR
   } acc_e;

   localparam logic [7:0] ERR_INIT  = 8'h01;
   localparam logic [7:0] SCNT_INIT = 8'h01;
   localparam logic [7:0] SNUM_INIT = 8'h01;
   localparam logic [7:0] CYL_INIT  = 8'h00;
   localparam int unsigned DEVCTL_SRST_BIT = 2;
   localparam int unsigned DEVCTL_NIEN_BIT = 1;
   localparam int unsigned DH_DRV_BIT      = 4;

   function automatic logic is_cmd_blk(acc_e a);
      return (a == ACC_DATA) || (a == ACC_ERRPC) || (a == ACC_SCNT) ||
             (a == ACC_SNUM) || (a == ACC_CYLLO) || (a == ACC_CYLHI) ||
             (a == ACC_DRVHD) || (a == ACC_STATCMD);
   endfunction
endpackage

// File: rtl/tfr_strobe.sv
module tfr_strobe #(
   parameter int unsigned STAGES = 2
) (
   input  logic clk,
   input  logic rst_n,
   input  logic strobe_n,
   output logic rise,
   output logic fall
);
   logic [STAGES-1:0] chain;
   logic              prev;

   generate
      if (STAGES < 2) begin : g_bad
         $error("tfr_strobe needs at least two synchronizer stages");
      end
   endgenerate

   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) begin
         chain <= '1;
         prev  <= 1'b1;
      end else begin
         chain <= {chain[STAGES-2:0], strobe_n};
         prev  <= chain[STAGES-1];
      end
   end

   assign rise = chain[STAGES-1] & ~prev;
   assign fall = ~chain[STAGES-1] & prev;
endmodule

// File: rtl/tfr_decode.sv
module tfr_decode
   import tfr_pkg::*;
(
   input  logic       cs_cmd_n,
   input  logic       cs_ctl_n,
   input  logic [2:0] addr,
   output acc_e       acc
);
   always_comb begin
      acc = ACC_NONE;
      if (!cs_cmd_n && cs_ctl_n) begin
         case (addr)
            3'd0:    acc = ACC_DATA;
            3'd1:    acc = ACC_ERRPC;
            3'd2:    acc = ACC_SCNT;
            3'd3:    acc = ACC_SNUM;
            3'd4:    acc = ACC_CYLLO;
            3'd5:    acc = ACC_CYLHI;
            3'd6:    acc = ACC_DRVHD;
            default: acc = ACC_STATCMD;
         endcase
      end else if (cs_cmd_n && !cs_ctl_n) begin
         if (addr == 3'd6)      acc = ACC_ALTDEV;
         else if (addr == 3'd7) acc = ACC_DADDR;
      end
   end
endmodule

// File: rtl/tfr_regs.sv
module tfr_regs
   import tfr_pkg::*;
#(
   parameter int unsigned DW     = 16,
   parameter int unsigned RW     = 8,
   parameter int unsigned HEAD_W = 4
) (
   input  logic              clk,
   input  logic              rst_n,
   input  acc_e              acc,
   input  logic              wr_rise,
   input  logic              rd_fall,
   input  logic [DW-1:0]     wdata,
   input  logic              busy,
   input  logic              ld,
   input  logic [RW-1:0]     ld_scnt,
   input  logic [RW-1:0]     ld_snum,
   input  logic [2*RW-1:0]   ld_cyl,
   input  logic [HEAD_W-1:0] ld_head,
   input  logic [RW-1:0]     ld_err,
   output logic [RW-1:0]     err_q,
   output logic [RW-1:0]     scnt_q,
   output logic [RW-1:0]     snum_q,
   output logic [2*RW-1:0]   cyl_q,
   output logic              drv_q,
   output logic [HEAD_W-1:0] head_q,
   output logic              srst_q,
   output logic              nien_q,
   output logic              cmd_stb,
   output logic [RW-1:0]     cmd_code,
   output logic              dp_wr_stb,
   output logic [DW-1:0]     dp_wdata,
   output logic              dp_rd_stb
);
   logic host_wr_ok;
   assign host_wr_ok = wr_rise && !busy && !srst_q && is_cmd_blk(acc);

   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) begin
         srst_q <= 1'b0;
         nien_q <= 1'b0;
      end else if (wr_rise && acc == ACC_ALTDEV) begin
         srst_q <= wdata[DEVCTL_SRST_BIT];
         nien_q <= wdata[DEVCTL_NIEN_BIT];
      end
   end

   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) begin
         err_q  <= ERR_INIT;
         scnt_q <= SCNT_INIT;
         snum_q <= SNUM_INIT;
         cyl_q  <= {CYL_INIT, CYL_INIT};
         drv_q  <= 1'b0;
         head_q <= '0;
      end else if (srst_q) begin
         err_q  <= ERR_INIT;
         scnt_q <= SCNT_INIT;
         snum_q <= SNUM_INIT;
         cyl_q  <= {CYL_INIT, CYL_INIT};
         drv_q  <= 1'b0;
         head_q <= '0;
      end else if (ld) begin
         err_q  <= ld_err;
         scnt_q <= ld_scnt;
         snum_q <= ld_snum;
         cyl_q  <= ld_cyl;
         head_q <= ld_head;
      end else if (host_wr_ok) begin
         case (acc)
            ACC_SCNT:  scnt_q <= wdata[RW-1:0];
            ACC_SNUM:  snum_q <= wdata[RW-1:0];
            ACC_CYLLO: cyl_q[RW-1:0] <= wdata[RW-1:0];
            ACC_CYLHI: cyl_q[2*RW-1:RW] <= wdata[RW-1:0];
            ACC_DRVHD: begin
               drv_q  <= wdata[DH_DRV_BIT];
               head_q <= wdata[HEAD_W-1:0];
            end
            default: ;
         endcase
      end
   end

   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) begin
         cmd_stb   <= 1'b0;
         cmd_code  <= '0;
         dp_wr_stb <= 1'b0;
         dp_wdata  <= '0;
         dp_rd_stb <= 1'b0;
      end else begin
         cmd_stb   <= host_wr_ok && acc == ACC_STATCMD;
         dp_wr_stb <= host_wr_ok && acc == ACC_DATA;
         dp_rd_stb <= rd_fall && !busy && acc == ACC_DATA;
         if (host_wr_ok && acc == ACC_STATCMD) cmd_code <= wdata[RW-1:0];
         if (host_wr_ok && acc == ACC_DATA)    dp_wdata <= wdata;
      end
   end
endmodule

// File: rtl/tfr_bank.sv
module tfr_bank
   import tfr_pkg::*;
#(
   parameter int unsigned DW          = 16,
   parameter int unsigned RW          = 8,
   parameter int unsigned HEAD_W      = 4,
   parameter int unsigned SYNC_STAGES = 2
) (
   input  logic              clk,
   input  logic              rst_n,
   input  logic              host_cs_cmd_n,
   input  logic              host_cs_ctl_n,
   input  logic [2:0]        host_addr,
   input  logic              host_rd_n,
   input  logic              host_wr_n,
   input  logic [DW-1:0]     host_din,
   output logic [DW-1:0]     host_dout,
   output logic [DW-1:0]     host_oe,
   output logic              host_cs16_n,
   input  logic [RW-1:0]     ctl_status,
   input  logic              ctl_wgate_n,
   input  logic              ctl_load,
   input  logic [RW-1:0]     ctl_scnt,
   input  logic [RW-1:0]     ctl_snum,
   input  logic [2*RW-1:0]   ctl_cyl,
   input  logic [HEAD_W-1:0] ctl_head,
   input  logic [RW-1:0]     ctl_err,
   input  logic [DW-1:0]     dp_rdata,
   output logic              dp_rd_stb,
   output logic              dp_wr_stb,
   output logic [DW-1:0]     dp_wdata,
   output logic              cmd_stb,
   output logic [RW-1:0]     cmd_code,
   output logic [RW-1:0]     scnt,
   output logic [RW-1:0]     snum,
   output logic [2*RW-1:0]   cyl,
   output logic              drv,
   output logic [HEAD_W-1:0] head,
   output logic              srst,
   output logic              nien
);
   localparam int unsigned HI_W = DW - RW;

   generate
      if (DW != 2 * RW) begin : g_bad_dw
         $error("data bus must be twice the register width");
      end
      if (RW != 8) begin : g_bad_rw
         $error("register width must be 8");
      end
      if (HEAD_W < 1 || HEAD_W > 4) begin : g_bad_head
         $error("head field must be 1 to 4 bits");
      end
   endgenerate

   acc_e          acc;
   logic          wr_rise, wr_fall, rd_rise, rd_fall;
   logic [RW-1:0] err_q;
   logic          busy;
   logic [RW-1:0] rd_byte;
   logic [RW-1:0] oe_lo;
   logic          hi_en;
   logic [3:0]    head4;

   assign busy  = ctl_status[RW-1];
   assign head4 = 4'(head);

   tfr_decode u_dec (
      .cs_cmd_n (host_cs_cmd_n),
      .cs_ctl_n (host_cs_ctl_n),
      .addr     (host_addr),
      .acc      (acc)
   );

   tfr_strobe #(.STAGES(SYNC_STAGES)) u_wr_sync (
      .clk (clk), .rst_n (rst_n), .strobe_n (host_wr_n),
      .rise (wr_rise), .fall (wr_fall)
   );

   tfr_strobe #(.STAGES(SYNC_STAGES)) u_rd_sync (
      .clk (clk), .rst_n (rst_n), .strobe_n (host_rd_n),
      .rise (rd_rise), .fall (rd_fall)
   );

   tfr_regs #(.DW(DW), .RW(RW), .HEAD_W(HEAD_W)) u_regs (
      .clk       (clk),
      .rst_n     (rst_n),
      .acc       (acc),
      .wr_rise   (wr_rise),
      .rd_fall   (rd_fall),
      .wdata     (host_din),
      .busy      (busy),
      .ld        (ctl_load),
      .ld_scnt   (ctl_scnt),
      .ld_snum   (ctl_snum),
      .ld_cyl    (ctl_cyl),
      .ld_head   (ctl_head),
      .ld_err    (ctl_err),
      .err_q     (err_q),
      .scnt_q    (scnt),
      .snum_q    (snum),
      .cyl_q     (cyl),
      .drv_q     (drv),
      .head_q    (head),
      .srst_q    (srst),
      .nien_q    (nien),
      .cmd_stb   (cmd_stb),
      .cmd_code  (cmd_code),
      .dp_wr_stb (dp_wr_stb),
      .dp_wdata  (dp_wdata),
      .dp_rd_stb (dp_rd_stb)
   );

   always_comb begin
      rd_byte = '0;
      oe_lo   = '1;
      hi_en   = 1'b0;
      if (busy && is_cmd_blk(acc)) begin
         rd_byte = ctl_status;
      end else begin
         case (acc)
            ACC_DATA: begin
               rd_byte = dp_rdata[RW-1:0];
               hi_en   = 1'b1;
            end
            ACC_ERRPC:   rd_byte = err_q;
            ACC_SCNT:    rd_byte = scnt;
            ACC_SNUM:    rd_byte = snum;
            ACC_CYLLO:   rd_byte = cyl[RW-1:0];
            ACC_CYLHI:   rd_byte = cyl[2*RW-1:RW];
            ACC_DRVHD:   rd_byte = {3'b101, drv, head4};
            ACC_STATCMD: rd_byte = ctl_status;
            ACC_ALTDEV:  rd_byte = ctl_status;
            ACC_DADDR: begin
               rd_byte = {1'b0, ctl_wgate_n, ~head4, ~drv, drv};
               oe_lo   = {1'b0, {(RW-1){1'b1}}};
            end
            default: oe_lo = '0;
         endcase
      end
   end

   assign host_dout   = {hi_en ? dp_rdata[DW-1:RW] : {HI_W{1'b0}}, rd_byte};
   assign host_oe     = host_rd_n ? '0 : {{HI_W{hi_en}}, oe_lo};
   assign host_cs16_n = !(acc == ACC_DATA && !busy);
endmodule

// File: rtl/tfr_bank_chk.sv
module tfr_bank_chk #(
   parameter int unsigned DW = 16,
   parameter int unsigned RW = 8
) (
   input logic          clk,
   input logic          rst_n,
   input logic          host_cs_cmd_n,
   input logic          host_cs_ctl_n,
   input logic [2:0]    host_addr,
   input logic          host_rd_n,
   input logic [DW-1:0] host_dout,
   input logic [DW-1:0] host_oe,
   input logic          host_cs16_n,
   input logic [RW-1:0] ctl_status,
   input logic          cmd_stb
);
   logic cmd_rd;
   assign cmd_rd = !host_rd_n && !host_cs_cmd_n && host_cs_ctl_n;

   assert_float_R2: assert property (@(posedge clk) disable iff (!rst_n)
      (host_rd_n || (host_cs_cmd_n == host_cs_ctl_n)) |-> host_oe == '0);

   assert_busy_status_R4: assert property (@(posedge clk) disable iff (!rst_n)
      (cmd_rd && ctl_status[RW-1]) |-> host_dout[RW-1:0] == ctl_status);

   assert_busy_drop_R5: assert property (@(posedge clk) disable iff (!rst_n)
      cmd_stb |-> !$past(ctl_status[RW-1]));

   assert_dh_fixed_R6: assert property (@(posedge clk) disable iff (!rst_n)
      (cmd_rd && host_addr == 3'd6 && !ctl_status[RW-1]) |-> host_dout[7:5] == 3'b101);

   assert_daddr_bit7_R7: assert property (@(posedge clk) disable iff (!rst_n)
      (!host_rd_n && host_cs_cmd_n && !host_cs_ctl_n && host_addr == 3'd7) |-> !host_oe[7]);

   assert_cmd_pulse_R8: assert property (@(posedge clk) disable iff (!rst_n)
      cmd_stb |=> !cmd_stb);

   assert_upper_dp_R10: assert property (@(posedge clk) disable iff (!rst_n)
      (host_oe[DW-1:RW] != '0) |-> !host_cs16_n);
endmodule

bind tfr_bank tfr_bank_chk #(.DW(DW), .RW(RW)) u_chk (
   .clk           (clk),
   .rst_n         (rst_n),
   .host_cs_cmd_n (host_cs_cmd_n),
   .host_cs_ctl_n (host_cs_ctl_n),
   .host_addr     (host_addr),
   .host_rd_n     (host_rd_n),
   .host_dout     (host_dout),
   .host_oe       (host_oe),
   .host_cs16_n   (host_cs16_n),
   .ctl_status    (ctl_status),
   .cmd_stb       (cmd_stb)
);

// File: tb/tfr_bank_test.sv
module tfr_bank_test;
   logic        clk = 1'b0;
   logic        rst_n = 1'b0;
   logic        cs_cmd_n = 1'b1, cs_ctl_n = 1'b1;
   logic [2:0]  addr = '0;
   logic        rd_n = 1'b1, wr_n = 1'b1;
   logic [15:0] din = '0;
   logic [15:0] dout, oe;
   logic        cs16_n;
   logic [7:0]  status = 8'h50;
   logic        wgate_n = 1'b1;
   logic        ld = 1'b0;
   logic [7:0]  ld_scnt = '0, ld_snum = '0, ld_err = '0;
   logic [15:0] ld_cyl = '0;
   logic [3:0]  ld_head = '0;
   logic [15:0] dp_rdata = 16'hCAFE;
   logic        dp_rd_stb, dp_wr_stb, cmd_stb, srst, nien, drv;
   logic [15:0] dp_wdata, cyl;
   logic [7:0]  cmd_code, scnt, snum;
   logic [3:0]  head;

   int checks = 0;
   int fails  = 0;
   logic [17:0] exp_q[$];   // {kind[1:0], value[15:0]}: 0 cmd, 1 dp write, 2 dp read

   always #5 clk = ~clk;

   tfr_bank uut (
      .clk(clk), .rst_n(rst_n), .host_cs_cmd_n(cs_cmd_n), .host_cs_ctl_n(cs_ctl_n),
      .host_addr(addr), .host_rd_n(rd_n), .host_wr_n(wr_n), .host_din(din),
      .host_dout(dout), .host_oe(oe), .host_cs16_n(cs16_n),
      .ctl_status(status), .ctl_wgate_n(wgate_n), .ctl_load(ld),
      .ctl_scnt(ld_scnt), .ctl_snum(ld_snum), .ctl_cyl(ld_cyl), .ctl_head(ld_head),
      .ctl_err(ld_err), .dp_rdata(dp_rdata), .dp_rd_stb(dp_rd_stb),
      .dp_wr_stb(dp_wr_stb), .dp_wdata(dp_wdata), .cmd_stb(cmd_stb),
      .cmd_code(cmd_code), .scnt(scnt), .snum(snum), .cyl(cyl), .drv(drv),
      .head(head), .srst(srst), .nien(nien)
   );

   task automatic chk(input string tag, input logic [31:0] got, input logic [31:0] exp);
      checks++;
      if (got !== exp) begin
         fails++;
         $display("FAIL %s: got %h expected %h", tag, got, exp);
      end
   endtask

   // scoreboard monitor
   always @(negedge clk) begin
      if (rst_n && (cmd_stb || dp_wr_stb || dp_rd_stb)) begin
         logic [17:0] got;
         got = cmd_stb ? {2'd0, 8'h00, cmd_code} :
               dp_wr_stb ? {2'd1, dp_wdata} : {2'd2, 16'h0000};
         if (exp_q.size() == 0) chk("R5/R8 unexpected strobe", 32'(got), 32'h3FFFF);
         else chk("R8/R10 strobe", 32'(got), 32'(exp_q.pop_front()));
      end
   end

   task automatic sel(input logic cmd, input logic ctl, input logic [2:0] a);
      cs_cmd_n = ~cmd; cs_ctl_n = ~ctl; addr = a;
   endtask

   task automatic host_wr(input logic cmd, input logic ctl, input logic [2:0] a,
                          input logic [15:0] d);
      @(negedge clk);
      sel(cmd, ctl, a); din = d; wr_n = 1'b0;
      repeat (3) @(negedge clk);
      wr_n = 1'b1;
      repeat (5) @(negedge clk);
      sel(1'b0, 1'b0, 3'd0);
   endtask

   task automatic host_rd(input logic cmd, input logic ctl, input logic [2:0] a,
                          output logic [15:0] d, output logic [15:0] e);
      @(negedge clk);
      sel(cmd, ctl, a); rd_n = 1'b0;
      repeat (4) @(negedge clk);
      d = dout; e = oe;
      rd_n = 1'b1;
      repeat (4) @(negedge clk);
      sel(1'b0, 1'b0, 3'd0);
   endtask

   task automatic rd_byte(input logic [2:0] a, input string tag, input logic [7:0] exp);
      logic [15:0] d, e;
      host_rd(1'b1, 1'b0, a, d, e);
      chk(tag, {16'h0, e[15:8], d[7:0]}, {24'h0, exp});
   endtask

   initial begin
      logic [15:0] d, e;
      repeat (3) @(negedge clk);
      rst_n = 1'b1;
      repeat (2) @(negedge clk);

      // reset values
      rd_byte(3'd1, "R3 error", 8'h01);
      rd_byte(3'd2, "R3 sector count", 8'h01);
      rd_byte(3'd3, "R3 sector number", 8'h01);
      rd_byte(3'd4, "R3 cyl low", 8'h00);
      rd_byte(3'd5, "R3 cyl high", 8'h00);
      rd_byte(3'd6, "R3/R6 drive-head", 8'hA0);
      rd_byte(3'd7, "R1 status", 8'h50);

      // register writes
      host_wr(1'b1, 1'b0, 3'd2, 16'h0012);
      host_wr(1'b1, 1'b0, 3'd3, 16'h0034);
      host_wr(1'b1, 1'b0, 3'd4, 16'h0056);
      host_wr(1'b1, 1'b0, 3'd5, 16'h0078);
      rd_byte(3'd2, "R1 sector count", 8'h12);
      rd_byte(3'd3, "R1 sector number", 8'h34);
      rd_byte(3'd4, "R1 cyl low", 8'h56);
      rd_byte(3'd5, "R1 cyl high", 8'h78);
      host_wr(1'b1, 1'b0, 3'd6, 16'h001B);
      rd_byte(3'd6, "R6 drv1 head B", 8'hBB);
      host_wr(1'b1, 1'b0, 3'd6, 16'h004B);
      rd_byte(3'd6, "R6 drv0 head B", 8'hAB);

      // drive address: bit7 off, wgate 1, ~B=0100, nds1=1, nds0=0
      host_rd(1'b0, 1'b1, 3'd7, d, e);
      chk("R7 drive address", {d & e, e}, {16'h0052, 16'h007F});
      wgate_n = 1'b0;
      host_rd(1'b0, 1'b1, 3'd7, d, e);
      chk("R7 write gate low", 32'(d[6]), 32'h0);
      wgate_n = 1'b1;

      // precompensation ignored
      host_wr(1'b1, 1'b0, 3'd1, 16'h00EE);
      rd_byte(3'd1, "R9 error after precomp write", 8'h01);

      // command write
      exp_q.push_back({2'd0, 16'h0020});
      host_wr(1'b1, 1'b0, 3'd7, 16'h0020);

      // data port
      @(negedge clk); sel(1'b1, 1'b0, 3'd0); #1;
      chk("R10 cs16 low on data port", 32'(cs16_n), 32'h0);
      exp_q.push_back({2'd1, 16'hBEEF});
      host_wr(1'b1, 1'b0, 3'd0, 16'hBEEF);
      exp_q.push_back({2'd2, 16'h0000});
      host_rd(1'b1, 1'b0, 3'd0, d, e);
      chk("R10 data port read", {d, e}, {16'hCAFE, 16'hFFFF});
      @(negedge clk); sel(1'b1, 1'b0, 3'd2); #1;
      chk("R10 cs16 high off data port", 32'(cs16_n), 32'h1);

      // floating and ignored accesses
      host_rd(1'b0, 1'b0, 3'd2, d, e);
      chk("R2 no select float", 32'(e), 32'h0);
      host_rd(1'b1, 1'b1, 3'd2, d, e);
      chk("R2 both selects float", 32'(e), 32'h0);
      host_rd(1'b0, 1'b1, 3'd3, d, e);
      chk("R2 control offset 3 float", 32'(e), 32'h0);
      host_wr(1'b1, 1'b1, 3'd2, 16'h00AA);
      host_wr(1'b0, 1'b1, 3'd2, 16'h00BB);
      host_wr(1'b0, 1'b0, 3'd2, 16'h00CC);
      rd_byte(3'd2, "R2 ignored writes", 8'h12);

      // busy lockout
      status = 8'hD0;
      rd_byte(3'd2, "R4 busy read sector count", 8'hD0);
      host_rd(1'b1, 1'b0, 3'd0, d, e);
      chk("R4 busy data port", {8'h00, d[7:0], e}, {16'h00D0, 16'h00FF});
      chk("R4 busy cs16", 32'(cs16_n), 32'h1);
      host_wr(1'b1, 1'b0, 3'd2, 16'h0077);
      host_wr(1'b1, 1'b0, 3'd7, 16'h00EC);
      host_wr(1'b0, 1'b1, 3'd6, 16'h000A);
      chk("R5/R11 devctl during busy nien", {31'h0, nien}, 32'h1);
      status = 8'h50;
      rd_byte(3'd2, "R5 write dropped", 8'h12);

      // busy rises after the strobe released but before edge detect
      @(negedge clk);
      sel(1'b1, 1'b0, 3'd2); din = 16'h0066; wr_n = 1'b0;
      repeat (3) @(negedge clk);
      wr_n = 1'b1; status = 8'hD0;
      repeat (5) @(negedge clk);
      status = 8'h50;
      rd_byte(3'd2, "R5 busy race dropped", 8'h12);

      // alt status and soft reset
      status = 8'h58;
      host_rd(1'b0, 1'b1, 3'd6, d, e);
      chk("R7 alt status", {d[7:0], e[7:0]}, {8'h58, 8'hFF});
      status = 8'h50;
      host_wr(1'b0, 1'b1, 3'd6, 16'h000C);
      chk("R11 srst out", {30'h0, srst, nien}, 32'h2);
      rd_byte(3'd2, "R11 sector count under srst", 8'h01);
      host_wr(1'b0, 1'b1, 3'd6, 16'h0008);
      chk("R11 srst cleared", {30'h0, srst, nien}, 32'h0);
      rd_byte(3'd6, "R11 drive-head after srst", 8'hA0);

      // controller load
      @(negedge clk);
      ld_scnt = 8'h00; ld_snum = 8'h05; ld_cyl = 16'h1234; ld_head = 4'h3; ld_err = 8'h04;
      ld = 1'b1;
      @(negedge clk); ld = 1'b0;
      rd_byte(3'd1, "R12 error", 8'h04);
      rd_byte(3'd2, "R12 sector count", 8'h00);
      rd_byte(3'd3, "R12 sector number", 8'h05);
      rd_byte(3'd4, "R12 cyl low", 8'h34);
      rd_byte(3'd5, "R12 cyl high", 8'h12);
      rd_byte(3'd6, "R12 head", 8'hA3);

      chk("R8 scoreboard drained", 32'(exp_q.size()), 32'h0);
      $display("%0d/%0d checks passed", checks - fails, checks);
      $finish;
   end

   initial begin
      repeat (20000) @(posedge clk);
      checks++; fails++;
      $display("FAIL watchdog: got timeout expected completion");
      $display("%0d/%0d checks passed", checks - fails, checks);
      $finish;
   end
endmodule